// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block sits behind the receive MAC and judges each incoming Ethernet frame as it streams past, one byte per valid beat. It watches the first six bytes to classify the destination as broadcast, multicast or a unicast hit on this station's address. It counts the frame length, including the four CRC bytes. It takes the CRC verdict that the MAC presents together with the last byte. One cycle after the last byte, it issues a single accept-or-discard verdict that the receive path uses to keep or drop the buffered frame.

Software controls the block through an 8-bit filter-enable word and three 16-bit station-address words. The enable word holds three independent class enables and two reject conditions, one for short frames and one for bad CRC. The longest frame the block accepts is a build parameter, 1536 bytes by default, so VLAN-tagged frames still pass. Longer frames are always discarded, and their verdict carries a length-error flag.

Top module: `rx_accept_filter`

## Requirements
- R1: After reset, `decValid`, `accept` and `lenErr` are all 0 until a frame ends.
- R2: With `filterEn` bit 0 set, a frame whose destination is all ones (FF:FF:FF:FF:FF:FF) is accepted. With bit 0 clear and no other class enabled that matches, it is discarded.
- R3: With `filterEn` bit 1 set, a frame is accepted if bit 0 of its first destination byte is 1 and the destination is not all ones. Enabling only the broadcast class does not accept such a frame.
- R4: With `filterEn` bit 3 set, a frame whose destination equals the station address is accepted. Destination byte 0 (the first byte on the wire) is compared with `staAddrHi[7:0]` and byte 1 with `staAddrHi[15:8]`. Bytes 2 and 3 are compared with `staAddrMid[7:0]` and `staAddrMid[15:8]`. Bytes 4 and 5 are compared with `staAddrLo[7:0]` and `staAddrLo[15:8]`.
- R5: A frame that matches no enabled class is discarded. This covers a frame shorter than 6 bytes, which matches no class.
- R6: With `filterEn` bit 4 set, a frame of fewer than 64 bytes is discarded, while a 64-byte frame is not affected. With bit 4 clear, frame length below 64 has no effect.
- R7: With `filterEn` bit 5 set, a frame whose `crcGood` is 0 on its last byte is discarded. With bit 5 clear, `crcGood` has no effect.
- R8: A frame longer than MAX_LEN (default 1536) bytes is discarded regardless of enables, and its verdict has `lenErr` = 1. A frame of exactly MAX_LEN bytes is accepted if otherwise eligible and has `lenErr` = 0.
- R9: Each frame produces exactly one `decValid` pulse, one cycle wide, in the cycle after the beat that carries `rxEof`. `accept` and `lenErr` are 0 whenever `decValid` is 0.
- R10: Beats with `rxValid` = 0 are not counted. Bytes that arrive outside a frame, after its end and before the next `rxSof`, are ignored, even if they carry `rxEof`.
- R11: `filterEn` bits 2, 6 and 7 have no effect on the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Byte beat valid |
| rxData | input | 8 | Received byte |
| rxSof | input | 1 | Beat is the first byte of a frame |
| rxEof | input | 1 | Beat is the last byte of a frame |
| crcGood | input | 1 | CRC verdict from the MAC, sampled on the `rxEof` beat |
| filterEn | input | 8 | Class enables (bits 0, 1, 3) and reject conditions (bits 4, 5) |
| staAddrHi | input | 16 | Station address bytes 0 (low half) and 1 (high half) |
| staAddrMid | input | 16 | Station address bytes 2 (low half) and 3 (high half) |
| staAddrLo | input | 16 | Station address bytes 4 (low half) and 5 (high half) |
| decValid | output | 1 | Verdict strobe, one cycle after the end of a frame |
| accept | output | 1 | Frame is accepted (valid with `decValid`) |
| lenErr | output | 1 | Frame exceeded the maximum length (valid with `decValid`) |

## Verification
The bench probes the runt edge with frames of 63 and 64 bytes, and the length limit with frames of exactly the maximum and one byte longer. An off-by-one counter would flip one of each pair. It swaps the two halves of the highest address word to catch a reversed byte order in the station compare. It uses a multicast destination with only broadcast enabled to catch a class test that looks only at the group bit. Idle beats are inserted inside a 63-byte frame, so a counter that advanced on them would see a non-runt and accept it. Stray bytes carrying an end marker are sent between frames, so a design that did not track frame boundaries would emit an extra verdict.

// File: rtl/rx_filter_pkg.sv
package rx_filter_pkg;

  typedef struct packed {
    logic clear;    // first byte of a frame
    logic capture;  // byte belongs to a frame
    logic finish;   // last byte of a frame
  } filtStrobe_t;

  localparam int EN_BCAST = 0;
  localparam int EN_MCAST = 1;
  localparam int EN_UCAST = 3;
  localparam int EN_RUNT  = 4;
  localparam int EN_CRC   = 5;

  localparam int DEST_BYTES = 6;
  localparam int RUNT_BYTES = 64;

endpackage

// File: rtl/rx_filter_ctrl.sv
module rx_filter_ctrl
  import rx_filter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        rxSof,
  input  logic        rxEof,
  output filtStrobe_t strobe
);

  logic inFrame;

  always_comb begin
    strobe.clear   = rxValid & rxSof;
    strobe.capture = rxValid & (rxSof | inFrame);
    strobe.finish  = rxValid & (rxSof | inFrame) & rxEof;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame <= 1'b0;
    end else if (strobe.finish) begin
      inFrame <= 1'b0;
    end else if (strobe.clear) begin
      inFrame <= 1'b1;
    end
  end

endmodule

// File: rtl/rx_filter_dp.sv
module rx_filter_dp
  import rx_filter_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MAX_LEN = 1536
) (
  input  logic        clk,
  input  logic        rstN,
  input  filtStrobe_t strobe,
  input  logic [7:0]  rxData,
  input  logic        crcGood,
  input  logic [7:0]  filterEn,
  input  logic [15:0] staAddrHi,
  input  logic [15:0] staAddrMid,
  input  logic [15:0] staAddrLo,
  output logic        decValid,
  output logic        accept,
  output logic        lenErr
);

  localparam logic [CNT_W-1:0] DEST_L = CNT_W'(DEST_BYTES);
  localparam logic [CNT_W-1:0] RUNT_L = CNT_W'(RUNT_BYTES);
  localparam logic [CNT_W-1:0] MAX_L  = CNT_W'(MAX_LEN);
  localparam logic [CNT_W-1:0] SAT_L  = '1;

  // Station address as wire-order bytes: byte 0 is the first on the wire.
  logic [47:0] staFlat;
  logic [7:0]  staArr [DEST_BYTES];
  assign staFlat = {staAddrLo, staAddrMid, staAddrHi};

  genvar g;
  generate
    for (g = 0; g < DEST_BYTES; g++) begin : g_sta
      assign staArr[g] = staFlat[8*g +: 8];
    end
  endgenerate

  // Frame state
  logic [CNT_W-1:0] byteCnt;
  logic             allOnes;
  logic             selfHit;
  logic             groupBit;

  // Per-beat next values
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] lenNow;
  logic [7:0]       staByte;
  logic             inDest;
  logic             onesNow;
  logic             hitNow;
  logic             groupNow;

  always_comb begin
    idx     = strobe.clear ? '0 : byteCnt;
    lenNow  = (idx == SAT_L) ? SAT_L : idx + CNT_W'(1);
    inDest  = idx < DEST_L;
    staByte = 8'h00;
    for (int k = 0; k < DEST_BYTES; k++) begin
      if (idx == CNT_W'(k)) staByte = staArr[k];
    end
    onesNow  = (strobe.clear | allOnes) & (!inDest | (rxData == 8'hFF));
    hitNow   = (strobe.clear | selfHit) & (!inDest | (rxData == staByte));
    groupNow = strobe.clear ? rxData[0] : groupBit;
  end

  // Verdict for the closing beat
  logic destDone;
  logic isBcast;
  logic isMcast;
  logic isSelf;
  logic classOk;
  logic isRunt;
  logic tooLong;
  logic rejectAny;
  logic verdict;
  logic unusedEnBits;

  assign unusedEnBits = ^{filterEn[7:6], filterEn[2]};

  always_comb begin
    destDone  = lenNow >= DEST_L;
    isBcast   = destDone & onesNow;
    isMcast   = destDone & groupNow & !onesNow;
    isSelf    = destDone & hitNow;
    classOk   = (filterEn[EN_BCAST] & isBcast) |
                (filterEn[EN_MCAST] & isMcast) |
                (filterEn[EN_UCAST] & isSelf);
    isRunt    = lenNow < RUNT_L;
    tooLong   = lenNow > MAX_L;
    rejectAny = (filterEn[EN_RUNT] & isRunt) |
                (filterEn[EN_CRC] & !crcGood) |
                tooLong;
    verdict   = classOk & !rejectAny;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt  <= '0;
      allOnes  <= 1'b0;
      selfHit  <= 1'b0;
      groupBit <= 1'b0;
    end else if (strobe.capture) begin
      byteCnt  <= lenNow;
      allOnes  <= onesNow;
      selfHit  <= hitNow;
      groupBit <= groupNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid <= 1'b0;
      accept   <= 1'b0;
      lenErr   <= 1'b0;
    end else begin
      decValid <= strobe.finish;
      accept   <= strobe.finish & verdict;
      lenErr   <= strobe.finish & tooLong;
    end
  end

  // Assertions
  p_accept_with_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> decValid);

  p_lenerr_discards_r8: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |-> (decValid && !accept));

  p_crc_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(filterEn[EN_CRC]) && !$past(crcGood)) |-> !accept);

  p_runt_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && accept && $past(filterEn[EN_RUNT])) |-> ($past(lenNow) >= RUNT_L));

  p_no_class_r5: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && (($past(filterEn) & 8'h0B) == 8'h00)) |-> !accept);

endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
  import rx_filter_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MAX_LEN = 1536
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  input  logic        rxSof,
  input  logic        rxEof,
  input  logic        crcGood,
  input  logic [7:0]  filterEn,
  input  logic [15:0] staAddrHi,
  input  logic [15:0] staAddrMid,
  input  logic [15:0] staAddrLo,
  output logic        decValid,
  output logic        accept,
  output logic        lenErr
);

  filtStrobe_t strobe;

  rx_filter_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxValid (rxValid),
    .rxSof   (rxSof),
    .rxEof   (rxEof),
    .strobe  (strobe)
  );

  rx_filter_dp #(
    .CNT_W   (CNT_W),
    .MAX_LEN (MAX_LEN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rxData     (rxData),
    .crcGood    (crcGood),
    .filterEn   (filterEn),
    .staAddrHi  (staAddrHi),
    .staAddrMid (staAddrMid),
    .staAddrLo  (staAddrLo),
    .decValid   (decValid),
    .accept     (accept),
    .lenErr     (lenErr)
  );

endmodule

// File: tb/rx_accept_filter_test.sv
module rx_accept_filter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = 8'h00;
  logic        rxSof = 1'b0;
  logic        rxEof = 1'b0;
  logic        crcGood = 1'b0;
  logic [7:0]  filterEn = 8'h00;
  logic [15:0] staAddrHi;
  logic [15:0] staAddrMid;
  logic [15:0] staAddrLo;
  logic        decValid;
  logic        accept;
  logic        lenErr;

  localparam logic [47:0] STA = 48'h021A334C5D6E;
  localparam logic [47:0] BC  = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] MC  = 48'h01005E0000FB;

  // Wire byte 0 = STA[47:40] sits in staAddrHi[7:0].
  assign staAddrHi  = {STA[39:32], STA[47:40]};
  assign staAddrMid = {STA[23:16], STA[31:24]};
  assign staAddrLo  = {STA[7:0],   STA[15:8]};

  always #5 clk = ~clk;

  rx_accept_filter uut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .rxSof(rxSof), .rxEof(rxEof), .crcGood(crcGood), .filterEn(filterEn),
    .staAddrHi(staAddrHi), .staAddrMid(staAddrMid), .staAddrLo(staAddrLo),
    .decValid(decValid), .accept(accept), .lenErr(lenErr)
  );

  int checks = 0;
  int fails  = 0;
  int dvSeen = 0;
  int cyc    = 0;

  typedef struct packed {
    logic [47:0] dest;
    logic [15:0] len;
    logic        crc;
    logic [7:0]  en;
    logic        expAcc;
    logic        expLe;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{BC,  16'd64,   1'b1, 8'h01, 1'b1, 1'b0, 8'd2},   // R2 broadcast on
    '{BC,  16'd64,   1'b1, 8'h02, 1'b0, 1'b0, 8'd2},   // R2 broadcast off
    '{MC,  16'd64,   1'b1, 8'h02, 1'b1, 1'b0, 8'd3},   // R3 multicast on
    '{MC,  16'd64,   1'b1, 8'h01, 1'b0, 1'b0, 8'd3},   // R3 not broadcast
    '{STA, 16'd64,   1'b1, 8'h08, 1'b1, 1'b0, 8'd4},   // R4 station hit
    '{48'h021A334C5D6F, 16'd64, 1'b1, 8'h08, 1'b0, 1'b0, 8'd5}, // R5 last byte off
    '{48'h1A02334C5D6E, 16'd64, 1'b1, 8'h08, 1'b0, 1'b0, 8'd4}, // R4 byte order
    '{STA, 16'd63,   1'b1, 8'h1B, 1'b0, 1'b0, 8'd6},   // R6 runt rejected
    '{STA, 16'd63,   1'b1, 8'h0B, 1'b1, 1'b0, 8'd6},   // R6 runt allowed
    '{STA, 16'd64,   1'b1, 8'h1B, 1'b1, 1'b0, 8'd6},   // R6 boundary 64
    '{STA, 16'd64,   1'b0, 8'h2B, 1'b0, 1'b0, 8'd7},   // R7 CRC gated
    '{STA, 16'd64,   1'b0, 8'h0B, 1'b1, 1'b0, 8'd7},   // R7 CRC ignored
    '{STA, 16'd1536, 1'b1, 8'h3B, 1'b1, 1'b0, 8'd8},   // R8 exactly max
    '{STA, 16'd1537, 1'b1, 8'h0B, 1'b0, 1'b1, 8'd8},   // R8 over max
    '{STA, 16'd64,   1'b1, 8'hCC, 1'b1, 1'b0, 8'd11},  // R11 spare bits set
    '{STA, 16'd64,   1'b1, 8'hC4, 1'b0, 1'b0, 8'd11},  // R11 spare bits only
    '{BC,  16'd5,    1'b1, 8'h01, 1'b0, 1'b0, 8'd5},   // R5 short destination
    '{STA, 16'd64,   1'b1, 8'h03, 1'b0, 1'b0, 8'd5}    // R5 class disabled
  };

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(negedge clk) if (decValid === 1'b1) dvSeen++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  // Sends one frame; returns the sampled verdict and the pulse count.
  task automatic sendFrame(input logic [47:0] dest, input int len, input logic crc,
                           input logic [7:0] en, input int gap, input bit stray,
                           output logic gV, output logic gA, output logic gL,
                           output logic gNext, output int pulses);
    @(negedge clk);
    filterEn = en;
    dvSeen = 0;
    if (stray) begin
      for (int s = 0; s < 3; s++) begin
        @(negedge clk);
        rxValid = 1'b1; rxSof = 1'b0; rxEof = (s == 2); crcGood = 1'b1;
        rxData = 8'hFF;
      end
    end
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (gap > 0 && k > 0 && (k % gap) == 0) begin
        rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0; crcGood = 1'b0;
        rxData = 8'hFF;
        @(negedge clk);
      end
      rxValid = 1'b1;
      rxSof   = (k == 0);
      rxEof   = (k == len - 1);
      crcGood = (k == len - 1) ? crc : 1'b0;
      rxData  = (k < 6) ? dest[47 - 8*k -: 8] : (8'(k) ^ 8'hA5);
    end
    @(negedge clk);
    rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0; crcGood = 1'b0;
    gV = decValid; gA = accept; gL = lenErr;
    @(negedge clk);
    gNext = decValid;
    @(negedge clk);
    pulses = dvSeen;
  endtask

  initial begin
    logic gV, gA, gL, gN;
    int p;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 decValid after reset", decValid, 1'b0);
    check("R1 accept after reset", accept, 1'b0);
    check("R1 lenErr after reset", lenErr, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 decValid idle", decValid, 1'b0);

    for (int i = 0; i < NV; i++) begin
      sendFrame(VECS[i].dest, int'(VECS[i].len), VECS[i].crc, VECS[i].en, 0, 1'b0,
                gV, gA, gL, gN, p);
      check($sformatf("R%0d vec %0d decValid", VECS[i].req, i), gV, 1'b1);
      check($sformatf("R%0d vec %0d accept", VECS[i].req, i), gA, VECS[i].expAcc);
      check($sformatf("R%0d vec %0d lenErr", VECS[i].req, i), gL, VECS[i].expLe);
    end

    // R9 single pulse, one cycle wide
    sendFrame(STA, 64, 1'b1, 8'h08, 0, 1'b0, gV, gA, gL, gN, p);
    check("R9 decValid after eof", gV, 1'b1);
    check("R9 decValid drops next cycle", gN, 1'b0);
    check("R9 one pulse per frame", p == 1, 1'b1);

    // R10 idle beats do not count: 63 bytes with gaps is still a runt
    sendFrame(STA, 63, 1'b1, 8'h1B, 7, 1'b0, gV, gA, gL, gN, p);
    check("R10 gapped runt discarded", gA, 1'b0);
    sendFrame(STA, 64, 1'b1, 8'h1B, 5, 1'b0, gV, gA, gL, gN, p);
    check("R10 gapped 64-byte accepted", gA, 1'b1);

    // R10 stray bytes with an end marker between frames are ignored
    sendFrame(STA, 64, 1'b1, 8'h08, 0, 1'b1, gV, gA, gL, gN, p);
    check("R10 stray bytes give no verdict", p == 1, 1'b1);
    check("R10 frame after stray accepted", gA, 1'b1);

    summary();
    $finish;
  end

endmodule